// File: doc/BRIEF.md
# Configurable Sum-of-Products Term Array

This block evaluates a programmable AND plane that feeds a fixed OR plane. Ten primary inputs and eight feedback inputs are each presented to the plane twice, once as they are and once inverted, which gives 36 array lines. Each of the 74 product terms ANDs the lines chosen by its own 36-bit connection mask. Terms 0 to 63 are grouped eight at a time into eight OR sums. The remaining ten terms leave the block as separate control terms: eight enable terms, one preset term and one clear term. The path from the inputs to every output is purely combinational.

The connection masks sit in a configuration store that is written one term at a time. A write names a term index and a 36-bit mask. An erase request starts a sweep that clears one term per cycle in ascending index order. The small controller behind the load port has two named states. `ST_READY` accepts writes and erase requests. `ST_ERASE` clears term `cnt` on each cycle. The transition READY→ERASE is taken when an erase is requested. The transition ERASE→READY is taken after the last term has been cleared. While the controller is in ERASE, it stays there and steps its count.

Top module: `pterm_array`

## Requirements
- R1: Line 2k carries signal k as it is, and line 2k+1 carries signal k inverted. Signals 0–9 are `in_sig[9:0]` and signals 10–17 are `fb_sig[7:0]`. A term is 1 exactly when every line whose mask bit is set is 1.
- R2: A term whose mask is all zeros evaluates to 1 whatever the inputs are.
- R3: A term whose mask selects both lines of one signal evaluates to 0 whatever the inputs are.
- R4: `sum_out[g]` is the OR of terms 8g to 8g+7.
- R5: Terms 64 to 71 drive `oe_term[0]` to `oe_term[7]`. Term 72 drives `preset_term`. Term 73 drives `clear_term`.
- R6: In `ST_READY`, a write with `ld_we`=1 and `ld_idx` < 74 (and no erase request) stores `ld_mask` for that term at the clock edge. The outputs show the new mask from that edge on and are unchanged before it.
- R7: A write with `ld_idx` of 74 or more changes no mask.
- R8: After reset, every mask is cleared. All sum and control outputs are therefore 1, and `ld_busy` is 0.
- R9: An erase request in `ST_READY` raises `ld_busy` from the next edge for exactly 74 cycles. During that time terms are cleared in ascending order, and when the sweep ends every mask is zero.
- R10: Writes presented while `ld_busy` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Asynchronous active-low reset; clears all masks |
| in_sig | input | 10 | Primary input signals 0–9 |
| fb_sig | input | 8 | Feedback signals 10–17 |
| ld_we | input | 1 | Write strobe for one term mask |
| ld_idx | input | 7 | Term index for a write |
| ld_mask | input | 36 | Connection mask; bit n selects line n |
| ld_erase | input | 1 | Starts the clearing sweep |
| ld_busy | output | 1 | High while the sweep runs |
| sum_out | output | 8 | OR of each group of eight terms |
| oe_term | output | 8 | Enable terms 64–71 |
| preset_term | output | 1 | Term 72 |
| clear_term | output | 1 | Term 73 |

## Verification
Array outputs follow `in_sig` and `fb_sig` within the same cycle, so the bench changes the inputs and compares all 18 outputs a short delay later, before the next edge. A mask write takes effect at the edge that captures it. The bench therefore samples once in the cycle before that edge, where the old value is expected, and once after it, where the new value is expected. `ld_busy` rises at the edge that captures the erase request. The bench counts the falling edges on which it is high and expects 74. A write is injected after its target term has already been swept, so that a wrongly accepted write would still be visible once the sweep ends.

// File: rtl/pta_pkg.sv
package pta_pkg;
    typedef enum logic [0:0] {
        ST_READY = 1'b0,
        ST_ERASE = 1'b1
    } ld_state_t;
endpackage

// File: rtl/pta_line_gen.sv
module pta_line_gen #(
    parameter int N_SIG = 18
) (
    input  logic [N_SIG-1:0]   sig,
    output logic [2*N_SIG-1:0] lines
);
    for (genvar k = 0; k < N_SIG; k++) begin : g_pair
        assign lines[2*k]   = sig[k];
        assign lines[2*k+1] = ~sig[k];
    end
endmodule

// File: rtl/pta_cfg_store.sv
module pta_cfg_store
    import pta_pkg::*;
#(
    parameter int N_TERMS = 74,
    parameter int N_LINES = 36,
    parameter int IDX_W   = 7
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ld_we,
    input  logic [IDX_W-1:0]                 ld_idx,
    input  logic [N_LINES-1:0]               ld_mask,
    input  logic                             ld_erase,
    output logic                             busy,
    output logic [N_TERMS-1:0][N_LINES-1:0]  cfg_q
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_TERMS - 1);
    localparam logic [IDX_W-1:0] TERM_CNT = IDX_W'(N_TERMS);

    ld_state_t        state_q, state_d;
    logic [IDX_W-1:0] cnt_q, cnt_d;
    logic             wr_en, clr_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_READY: begin
                if (ld_erase) begin
                    state_d = ST_ERASE;
                    cnt_d   = '0;
                end
            end
            ST_ERASE: begin
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == LAST_IDX) begin
                    state_d = ST_READY;
                    cnt_d   = '0;
                end
            end
            default: state_d = ST_READY;
        endcase
    end

    always_comb begin
        busy   = 1'b0;
        clr_en = 1'b0;
        wr_en  = 1'b0;
        unique case (state_q)
            ST_READY: wr_en = ld_we && !ld_erase && (ld_idx < TERM_CNT);
            ST_ERASE: begin
                busy   = 1'b1;
                clr_en = 1'b1;
            end
            default: ;
        endcase
    end

    for (genvar t = 0; t < N_TERMS; t++) begin : g_row
        logic row_wr, row_clr;
        assign row_wr  = wr_en  && (ld_idx == IDX_W'(t));
        assign row_clr = clr_en && (cnt_q  == IDX_W'(t));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[t] <= '0;
            end else if (row_clr) begin
                cfg_q[t] <= '0;
            end else if (row_wr) begin
                cfg_q[t] <= ld_mask;
            end
        end
    end

    // R9: request in READY raises busy on the next cycle
    a_r9_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && ld_erase) |=> busy);

    // R9: sweep end leaves every mask cleared and busy low
    a_r9_sweep_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE && cnt_q == LAST_IDX) |=> (cfg_q == '0 && !busy));

    // R7: out-of-range index leaves the store untouched
    a_r7_idx_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && !ld_erase && ld_we && ld_idx >= TERM_CNT) |=> $stable(cfg_q));

    // R10: a write during the sweep to an already cleared term leaves it cleared
    a_r10_busy_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ld_we && ld_idx < cnt_q) |=> (cfg_q[$past(ld_idx)] == '0));
endmodule

// File: rtl/pta_term_eval.sv
module pta_term_eval #(
    parameter int N_TERMS = 74,
    parameter int N_LINES = 36
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [N_LINES-1:0]               lines,
    input  logic [N_TERMS-1:0][N_LINES-1:0]  cfg_q,
    output logic [N_TERMS-1:0]               terms
);
    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        assign terms[t] = &(lines | ~cfg_q[t]);

        // R2: an open term is true
        a_r2_open_true: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[t] == '0) |-> terms[t]);

        // R3: both polarities of signal 0 force the term false
        a_r3_both_false: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[t][0] && cfg_q[t][1]) |-> !terms[t]);
    end
endmodule

// File: rtl/pterm_array.sv
module pterm_array #(
    parameter int N_IN  = 10,
    parameter int N_FB  = 8,
    parameter int N_OUT = 8,
    parameter int TPO   = 8,
    parameter int IDX_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_IN-1:0]          in_sig,
    input  logic [N_FB-1:0]          fb_sig,
    input  logic                     ld_we,
    input  logic [IDX_W-1:0]         ld_idx,
    input  logic [2*(N_IN+N_FB)-1:0] ld_mask,
    input  logic                     ld_erase,
    output logic                     ld_busy,
    output logic [N_OUT-1:0]         sum_out,
    output logic [N_OUT-1:0]         oe_term,
    output logic                     preset_term,
    output logic                     clear_term
);
    localparam int N_SIG   = N_IN + N_FB;
    localparam int N_LINES = 2 * N_SIG;
    localparam int N_SUMT  = N_OUT * TPO;
    localparam int N_TERMS = N_SUMT + N_OUT + 2;

    logic [N_LINES-1:0]              lines;
    logic [N_TERMS-1:0][N_LINES-1:0] cfg_q;
    logic [N_TERMS-1:0]              terms;

    pta_line_gen #(.N_SIG(N_SIG)) u_lines (
        .sig   ({fb_sig, in_sig}),
        .lines (lines)
    );

    pta_cfg_store #(.N_TERMS(N_TERMS), .N_LINES(N_LINES), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_we    (ld_we),
        .ld_idx   (ld_idx),
        .ld_mask  (ld_mask),
        .ld_erase (ld_erase),
        .busy     (ld_busy),
        .cfg_q    (cfg_q)
    );

    pta_term_eval #(.N_TERMS(N_TERMS), .N_LINES(N_LINES)) u_eval (
        .clk   (clk),
        .rst_n (rst_n),
        .lines (lines),
        .cfg_q (cfg_q),
        .terms (terms)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_sum
        assign sum_out[g] = |terms[g*TPO +: TPO];
        assign oe_term[g] = terms[N_SUMT + g];

        // R4: an all-open group cannot give a low sum
        a_r4_open_group_high: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[g*TPO] == '0) |-> sum_out[g]);
    end

    assign preset_term = terms[N_SUMT + N_OUT];
    assign clear_term  = terms[N_SUMT + N_OUT + 1];
endmodule

// File: tb/pterm_array_bench.sv
module pterm_array_bench;
    localparam int NT = 74;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  in_sig = '0;
    logic [7:0]  fb_sig = '0;
    logic        ld_we = 1'b0;
    logic [6:0]  ld_idx = '0;
    logic [35:0] ld_mask = '0;
    logic        ld_erase = 1'b0;
    logic        ld_busy;
    logic [7:0]  sum_out, oe_term;
    logic        preset_term, clear_term;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [35:0] mdl [NT];

    always #10 clk = ~clk;

    pterm_array u_pterm_array (
        .clk(clk), .rst_n(rst_n), .in_sig(in_sig), .fb_sig(fb_sig),
        .ld_we(ld_we), .ld_idx(ld_idx), .ld_mask(ld_mask), .ld_erase(ld_erase),
        .ld_busy(ld_busy), .sum_out(sum_out), .oe_term(oe_term),
        .preset_term(preset_term), .clear_term(clear_term)
    );

    function automatic bit term_val(logic [35:0] m, logic [9:0] a, logic [7:0] b);
        logic [17:0] s;
        s = {b, a};
        for (int l = 0; l < 36; l++) begin
            bit v;
            v = (l % 2 == 1) ? !s[l/2] : s[l/2];
            if (m[l] && !v) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [17:0] expect_out(logic [9:0] a, logic [7:0] b);
        logic [17:0] r;
        r = '0;
        for (int g = 0; g < 8; g++)
            for (int j = 0; j < 8; j++)
                if (term_val(mdl[g*8+j], a, b)) r[g] = 1'b1;
        for (int g = 0; g < 8; g++) r[8+g] = term_val(mdl[64+g], a, b);
        r[16] = term_val(mdl[72], a, b);
        r[17] = term_val(mdl[73], a, b);
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_term(int idx, logic [35:0] m);
        @(negedge clk);
        ld_we = 1'b1; ld_idx = 7'(idx); ld_mask = m;
        @(negedge clk);
        ld_we = 1'b0;
        if (idx < NT) mdl[idx] = m;
    endtask

    task automatic apply_check(string req, logic [9:0] a, logic [7:0] b);
        in_sig = a; fb_sig = b;
        #1;
        check(req, {14'd0, clear_term, preset_term, oe_term, sum_out}, {14'd0, expect_out(a, b)});
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int bc;
        for (int t = 0; t < NT; t++) mdl[t] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: cleared store, everything high, not busy
        check("R8 outputs", {14'd0, clear_term, preset_term, oe_term, sum_out}, 32'h3FFFF);
        check("R8 busy", {31'd0, ld_busy}, 32'd0);

        // R6: write takes effect only at the capturing edge
        in_sig = '0; fb_sig = '0;
        ld_we = 1'b1; ld_idx = 7'd72; ld_mask = 36'h1;
        #1;
        check("R6 before edge", {31'd0, preset_term}, 32'd1);
        @(negedge clk);
        ld_we = 1'b0; mdl[72] = 36'h1;
        #1;
        check("R6 after edge", {31'd0, preset_term}, 32'd0);
        in_sig = 10'h1;
        #1;
        check("R1 preset follows line 0", {31'd0, preset_term}, 32'd1);

        // R2 R3 R1: program all terms with varied masks
        for (int t = 0; t < NT; t++) begin
            logic [35:0] m;
            m = '0;
            case (t % 5)
                0: m = '0;
                1: begin
                    m[2*(t%18)] = 1'b1; m[2*(t%18)+1] = 1'b1; m[(t*5)%36] = 1'b1;
                end
                default: begin
                    m[(t*7)%36] = 1'b1; m[(t*13+5)%36] = 1'b1;
                    if (t % 3 == 0) m[(t*3+11)%36] = 1'b1;
                end
            endcase
            write_term(t, m);
        end
        // R3: term 66 masks both lines of signal 0
        write_term(66, 36'h3);
        // R2: term 67 open
        write_term(67, 36'h0);
        // R4: group 1 all forced false except term 9 needing in_sig[3] high
        for (int j = 8; j < 16; j++) write_term(j, 36'h3);
        write_term(9, 36'h40);

        for (int v = 0; v < 1024; v++)
            apply_check("R1 R4 R5 sweep a", 10'(v), 8'(v ^ (v >> 2)));
        for (int v = 0; v < 1024; v++)
            apply_check("R1 R4 R5 sweep b", 10'(v), ~8'(v * 3));

        apply_check("R3 term66", 10'h3FF, 8'hFF);
        check("R3 oe_term[2]", {31'd0, oe_term[2]}, 32'd0);
        check("R2 oe_term[3]", {31'd0, oe_term[3]}, 32'd1);
        in_sig = 10'h008; #1;
        check("R4 group1 high", {31'd0, sum_out[1]}, 32'd1);
        in_sig = 10'h000; #1;
        check("R4 group1 low", {31'd0, sum_out[1]}, 32'd0);

        // R7: out-of-range writes change nothing
        for (int i = 74; i < 128; i++) write_term(i, '1);
        for (int v = 0; v < 64; v++)
            apply_check("R7 after bad idx", 10'(v * 17), 8'(v * 5));

        // R9 R10: erase sweep
        write_term(64, 36'h0);
        @(negedge clk);
        ld_erase = 1'b1;
        @(negedge clk);
        ld_erase = 1'b0;
        bc = 0;
        while (ld_busy && bc < 300) begin
            bc++;
            if (bc == 70) begin
                ld_we = 1'b1; ld_idx = 7'd64; ld_mask = 36'h3;
            end else begin
                ld_we = 1'b0;
            end
            @(negedge clk);
        end
        ld_we = 1'b0;
        check("R9 busy cycles", bc, 74);
        for (int t = 0; t < NT; t++) mdl[t] = '0;
        for (int v = 0; v < 32; v++)
            apply_check("R9 all open after erase", 10'(v * 31), 8'(v * 7));
        check("R10 oe_term[0] after busy write", {31'd0, oe_term[0]}, 32'd1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule